// File: doc/BRIEF.md
# Shadowed Real-Time Counter with Alarm

This peripheral keeps wall-clock time as a 32-bit count of seconds plus a 0 to 999 millisecond count. The millisecond count is advanced from a slow timekeeping clock of nominally 32 kHz by a fractional divider. The slow clock is sampled inside the bus clock domain, and each rising edge becomes a one-cycle tick. Software reaches the block through a plain register bus: address, write enable, read enable, write data and read data. Read data is combinational from the addressed register.

The running counters are not visible on the bus directly. Once in every eight slow ticks the block raises a busy flag for one slow tick. When that window closes, it posts the running seconds and milliseconds into bus-side copies. Writes to the time, alarm and mask registers are honoured only while the flag is low, and otherwise dropped. Software therefore waits for the busy flag to fall and then has the rest of the period for its writes.

A read of the milliseconds register also captures the posted seconds into a shadow register, so the two values form a coherent pair. Two seconds comparators set sticky interrupt status bits. The status bits are cleared by writing a one to them, and a mask selects which of them drive an active-high level interrupt.

Top module: `rtcShadowClock`

## Requirements
- R1: After reset, every readable register returns zero and `irq` is low.
- R2: The busy flag (bit 0 at offset 0x004) rises once every 8 slow-clock rising edges and stays high for exactly one slow-clock period.
- R3: The posted seconds (0x008) and milliseconds (0x010) change only when a busy window ends or when seconds are written. Two reads inside one non-busy window return the same value.
- R4: A read of the milliseconds register (0x010) loads the posted seconds into the shadow register (0x00C). No other access changes the shadow register.
- R5: Milliseconds count 0 to 999, and the step from 999 to 0 increments seconds. A seconds write clears the millisecond count and its divider, so milliseconds read back 0 right after the write.
- R6: Seconds are a full 32-bit unsigned count that wraps from 0xFFFFFFFF to 0.
- R7: Writes to seconds, alarm0 (0x014), alarm1 (0x018), millisecond alarm (0x01C) and mask (0x028) are dropped while busy is high. Status clears are always accepted.
- R8: When seconds step to a value equal to a non-zero alarm0, status bit 0 is set; alarm1 sets bit 1 in the same way. An alarm value of zero never fires, including on the wrap to zero.
- R9: Writing 1 to a status bit (0x02C, bits 4:0) clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R10: `irq` is high exactly while some status bit and its mask bit (0x028, same bit layout) are both 1.
- R11: All registers read back at their offsets: alarm0 0x014, alarm1 0x018, millisecond alarm 0x01C, mask 0x028.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowClk | input | 1 | Timekeeping clock, sampled and edge-detected |
| addr | input | ADDR_W | Register byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (needed for the shadow capture) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Active-high level interrupt |

## Verification
Read data is combinational, so the bench samples it one time unit after driving the address at a falling edge. Register writes and the shadow capture take effect at the next rising edge and are checked from the following falling edge onward. The busy flag has fixed timing: with the slow clock at four bus cycles, it is high for 4 bus cycles out of every 32, and the bench counts falling edges to confirm both numbers. The bench is built with the slow-clock rate reduced to 2000 Hz, so a second lasts 8000 bus cycles. Checks on seconds and alarms are placed after that interval plus a margin, and after the next busy window has closed.

// File: rtl/rtcShadowPkg.sv
package rtcShadowPkg;

  localparam int unsigned OFF_BUSY     = 32'h004;
  localparam int unsigned OFF_SEC      = 32'h008;
  localparam int unsigned OFF_SHADOW   = 32'h00C;
  localparam int unsigned OFF_MSEC     = 32'h010;
  localparam int unsigned OFF_ALARM0   = 32'h014;
  localparam int unsigned OFF_ALARM1   = 32'h018;
  localparam int unsigned OFF_MSALARM  = 32'h01C;
  localparam int unsigned OFF_MASK     = 32'h028;
  localparam int unsigned OFF_STATUS   = 32'h02C;

  localparam int EVT_W = 5;   // alarm0, alarm1, msec alarm, sec countdown, msec countdown
  localparam int N_SEC_ALARMS = 2;

  typedef struct packed {
    logic tick;
    logic copy;
    logic busy;
    logic wrSec;
    logic wrAlarm0;
    logic wrAlarm1;
    logic wrMsAlarm;
    logic wrMask;
    logic wrStatus;
    logic latchShadow;
  } rtcStrobes_t;

endpackage

// File: rtl/rtcShadowCtrl.sv
module rtcShadowCtrl
  import rtcShadowPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int POST_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output rtcStrobes_t       stb
);

  localparam int CNT_W = (POST_TICKS > 1) ? $clog2(POST_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(POST_TICKS - 1);

  logic [2:0]       syncQ;
  logic             tick;
  logic [CNT_W-1:0] tickCnt;
  logic             busyQ;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == off[ADDR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], slowClk};
  end

  assign tick = syncQ[1] & ~syncQ[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      busyQ   <= 1'b0;
    end else if (tick) begin
      tickCnt <= (tickCnt == LAST_TICK) ? '0 : tickCnt + 1'b1;
      if (busyQ)                       busyQ <= 1'b0;
      else if (tickCnt == LAST_TICK)   busyQ <= 1'b1;
    end
  end

  logic wrOk;
  assign wrOk = wrEn & ~busyQ;

  always_comb begin
    stb             = '0;
    stb.tick        = tick;
    stb.busy        = busyQ;
    stb.copy        = tick & busyQ;
    stb.wrSec       = wrOk & hit(addr, OFF_SEC);
    stb.wrAlarm0    = wrOk & hit(addr, OFF_ALARM0);
    stb.wrAlarm1    = wrOk & hit(addr, OFF_ALARM1);
    stb.wrMsAlarm   = wrOk & hit(addr, OFF_MSALARM);
    stb.wrMask      = wrOk & hit(addr, OFF_MASK);
    stb.wrStatus    = wrEn & hit(addr, OFF_STATUS);
    stb.latchShadow = rdEn & hit(addr, OFF_MSEC);
  end

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && tick) |=> !busyQ);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !tick) |=> busyQ);

endmodule

// File: rtl/rtcShadowData.sv
module rtcShadowData
  import rtcShadowPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SLOW_HZ    = 32768,
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);

  localparam int MS_W   = $clog2(MS_PER_SEC);
  localparam int FRAC_W = $clog2(SLOW_HZ + MS_PER_SEC) + 1;
  localparam logic [FRAC_W-1:0] FRAC_STEP = FRAC_W'(MS_PER_SEC);
  localparam logic [FRAC_W-1:0] FRAC_LIM  = FRAC_W'(SLOW_HZ);
  localparam logic [MS_W-1:0]   MS_LAST   = MS_W'(MS_PER_SEC - 1);

  logic [FRAC_W-1:0] fracAcc, fracSum;
  logic [MS_W-1:0]   msLive, msVis;
  logic [31:0]       secLive, secVis, secShadow, secNext;
  logic [31:0]       alarmSec [N_SEC_ALARMS];
  logic [31:0]       msAlarm;
  logic [EVT_W-1:0]  mask, status, evtSet, evtClr;
  logic              msStep, msWrap, secUpd;

  assign fracSum = fracAcc + FRAC_STEP;
  assign msStep  = stb.tick && (fracSum >= FRAC_LIM);
  assign msWrap  = msStep && (msLive == MS_LAST);
  assign secUpd  = stb.wrSec | msWrap;
  assign secNext = stb.wrSec ? wrData : secLive + 32'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fracAcc <= '0;
      msLive  <= '0;
      secLive <= '0;
    end else if (stb.wrSec) begin
      fracAcc <= '0;
      msLive  <= '0;
      secLive <= wrData;
    end else if (stb.tick) begin
      fracAcc <= msStep ? fracSum - FRAC_LIM : fracSum;
      if (msStep) msLive <= msWrap ? '0 : msLive + 1'b1;
      if (msWrap) secLive <= secNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secVis <= '0;
      msVis  <= '0;
    end else if (stb.wrSec) begin
      secVis <= wrData;
      msVis  <= '0;
    end else if (stb.copy) begin
      secVis <= secLive;
      msVis  <= msLive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                secShadow <= '0;
    else if (stb.latchShadow) secShadow <= secVis;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_SEC_ALARMS; i++) alarmSec[i] <= '0;
      msAlarm <= '0;
      mask    <= '0;
    end else begin
      if (stb.wrAlarm0)  alarmSec[0] <= wrData;
      if (stb.wrAlarm1)  alarmSec[1] <= wrData;
      if (stb.wrMsAlarm) msAlarm     <= wrData;
      if (stb.wrMask)    mask        <= wrData[EVT_W-1:0];
    end
  end

  always_comb begin
    evtSet = '0;
    for (int i = 0; i < N_SEC_ALARMS; i++)
      evtSet[i] = secUpd && (alarmSec[i] != '0) && (secNext == alarmSec[i]);
    evtClr = stb.wrStatus ? wrData[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~evtClr) | evtSet;
  end

  assign irq = |(status & mask);

  always_comb begin
    case (addr)
      ADDR_W'(OFF_BUSY):    rdData = {31'd0, stb.busy};
      ADDR_W'(OFF_SEC):     rdData = secVis;
      ADDR_W'(OFF_SHADOW):  rdData = secShadow;
      ADDR_W'(OFF_MSEC):    rdData = 32'(msVis);
      ADDR_W'(OFF_ALARM0):  rdData = alarmSec[0];
      ADDR_W'(OFF_ALARM1):  rdData = alarmSec[1];
      ADDR_W'(OFF_MSALARM): rdData = msAlarm;
      ADDR_W'(OFF_MASK):    rdData = 32'(mask);
      ADDR_W'(OFF_STATUS):  rdData = 32'(status);
      default:              rdData = '0;
    endcase
  end

  // R5
  ms_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    msLive < MS_W'(MS_PER_SEC));

  // R4
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchShadow |=> secShadow == $past(secVis));

  // R8
  alarm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> (alarmSec[0] != '0 && secLive == alarmSec[0]));

  // R7
  busy_drop_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy |=> ($stable(mask) && $stable(alarmSec[0]) && $stable(msAlarm)));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (status != '0 && mask != '0));

endmodule

// File: rtl/rtcShadowClock.sv
module rtcShadowClock
  import rtcShadowPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SLOW_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int POST_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);

  rtcStrobes_t stb;

  rtcShadowCtrl #(.ADDR_W(ADDR_W), .POST_TICKS(POST_TICKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .slowClk(slowClk),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  rtcShadowData #(.ADDR_W(ADDR_W), .SLOW_HZ(SLOW_HZ), .MS_PER_SEC(MS_PER_SEC)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

endmodule

// File: tb/test_rtcShadowClock.sv
module test_rtcShadowClock;

  localparam int ADDR_W = 8;
  localparam int SEC_CYC = 8000;   // 2000 slow ticks x 4 bus cycles

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slowClk = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              irq;

  int nChecks = 0;
  int nFails  = 0;

  always #5  clk = ~clk;
  always #20 slowClk = ~slowClk;

  rtcShadowClock #(.ADDR_W(ADDR_W), .SLOW_HZ(2000), .MS_PER_SEC(1000), .POST_TICKS(8)) i_rtcShadowClock (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busRead(input int unsigned a, output logic [31:0] v);
    @(negedge clk);
    addr = a[ADDR_W-1:0];
    rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic busWrite(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    addr = a[ADDR_W-1:0];
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitBusy(input logic lvl);
    addr = 8'h04;
    @(negedge clk);
    while (rdData[0] !== lvl) @(negedge clk);
  endtask

  task automatic waitSafe();
    waitBusy(1'b1);
    waitBusy(1'b0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    int unsigned offs [9] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h28, 8'h2C};
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      addr = offs[i][ADDR_W-1:0];
      #1 v = rdData;
      check("R1 reset register", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic testBusyPeriod();
    int hi = 0;
    int per = 0;
    waitBusy(1'b1);
    while (rdData[0] === 1'b1) begin @(negedge clk); hi++; per++; end
    while (rdData[0] === 1'b0) begin @(negedge clk); per++; end
    check("R2 busy high cycles", hi, 32'd4);
    check("R2 busy period cycles", per, 32'd32);
  endtask

  task automatic testAddrMap();
    logic [31:0] v;
    waitSafe();
    busWrite(8'h18, 32'h0000_0055);
    busWrite(8'h1C, 32'h0000_03E7);
    busWrite(8'h28, 32'h0000_0004);
    busRead(8'h18, v); check("R11 alarm1 readback", v, 32'h55);
    busRead(8'h1C, v); check("R11 msec alarm readback", v, 32'h3E7);
    busRead(8'h28, v); check("R11 mask readback", v, 32'h4);
    busRead(8'h2C, v); check("R11 status still clear", v, 32'h0);
    check("R10 no irq without status", {31'd0, irq}, 32'd0);
    waitSafe();
    busWrite(8'h28, 32'h0);
    busWrite(8'h18, 32'h0);
  endtask

  task automatic testDroppedWrite();
    logic [31:0] v;
    waitBusy(1'b1);
    busWrite(8'h28, 32'h1F);
    busRead(8'h28, v);
    check("R7 mask write during busy dropped", v, 32'h0);
  endtask

  task automatic testSecWriteAndStable();
    logic [31:0] a, b;
    waitSafe();
    busWrite(8'h08, 32'd5000);
    busRead(8'h10, a); check("R5 msec zero after seconds write", a, 32'd0);
    busRead(8'h08, a); check("R5 seconds written", a, 32'd5000);
    waitSafe();
    busRead(8'h10, a);
    repeat (12) @(negedge clk);
    busRead(8'h10, b);
    check("R3 msec stable inside window", b, a);
    nChecks++;
    if (a >= 32'd1000) begin
      nFails++;
      $display("FAIL R5 msec range: actual %0d expected below 1000", a);
    end
  endtask

  task automatic testShadow();
    logic [31:0] s, m, sh;
    waitSafe();
    busRead(8'h08, s);
    busRead(8'h10, m);
    busRead(8'h0C, sh);
    check("R4 shadow equals seconds after msec read", sh, s);
    repeat (SEC_CYC + 200) @(negedge clk);
    waitSafe();
    busRead(8'h0C, sh);
    check("R4 shadow unchanged without msec read", sh, s);
    busRead(8'h08, m);
    check("R5 seconds advanced by rollover", m, s + 32'd1);
    busRead(8'h10, m);
    busRead(8'h0C, sh);
    check("R4 shadow reloaded on msec read", sh, s + 32'd1);
  endtask

  task automatic testAlarm();
    logic [31:0] v;
    int waited = 0;
    waitSafe();
    busWrite(8'h08, 32'd100);
    busWrite(8'h14, 32'd101);
    busWrite(8'h28, 32'h1);
    @(negedge clk);
    while (irq !== 1'b1 && waited < SEC_CYC + 500) begin @(negedge clk); waited++; end
    check("R8 irq raised by alarm0", {31'd0, irq}, 32'd1);
    nChecks++;
    if (waited < SEC_CYC - 40) begin
      nFails++;
      $display("FAIL R8 alarm early: actual %0d expected near %0d", waited, SEC_CYC);
    end
    busRead(8'h2C, v); check("R8 status bit 0 set", v, 32'h1);
    busWrite(8'h2C, 32'h0);
    busRead(8'h2C, v); check("R9 write zero keeps status", v, 32'h1);
    waitSafe();
    busWrite(8'h28, 32'h1E);
    @(negedge clk);
    check("R10 irq low when bit masked", {31'd0, irq}, 32'd0);
    waitSafe();
    busWrite(8'h28, 32'h1);
    @(negedge clk);
    check("R10 irq back when unmasked", {31'd0, irq}, 32'd1);
    busWrite(8'h2C, 32'hFFFF_FFFF);
    busRead(8'h2C, v); check("R9 write one clears status", v, 32'h0);
    check("R10 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic testWrapZeroAlarm();
    logic [31:0] v;
    waitSafe();
    busWrite(8'h14, 32'd0);
    busWrite(8'h08, 32'hFFFF_FFFF);
    busWrite(8'h28, 32'h1);
    repeat (SEC_CYC + 200) @(negedge clk);
    waitSafe();
    busRead(8'h08, v); check("R6 seconds wrap to zero", v, 32'd0);
    busRead(8'h2C, v); check("R8 zero alarm never fires", v, 32'h0);
    check("R8 no irq on wrap", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBusyPeriod();
    testAddrMap();
    testDroppedWrite();
    testSecWriteAndStable();
    testShadow();
    testAlarm();
    testWrapZeroAlarm();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule